// File: doc/BRIEF.md
# Processor Status and Run-Control Register

This block holds the eight-bit status and control word that a small microcontroller core reads and writes at one I/O address. It tells reset firmware whether the last restart came from power-up or from the watchdog. It latches the sighting of an upstream bus reset (a long single-ended zero on the data lines) and shows whether an interrupt is pending and whether interrupts are globally enabled. It also decides whether the core runs, has halted or is parked in low-power suspend.

The core drives a one-cycle write strobe with data, plus one-cycle strobes for the halt, disable-interrupt, enable-interrupt and return-from-interrupt instructions. Event inputs come from the power-on reset (asynchronous, active low), the watchdog, the bus-reset detector, the bus-activity detector and the interrupt controller. Each state change shows on `stat_q` one clock after the edge that samples its cause. `run` and `susp_req` feed the core's sequencer and the clock-gating logic.

Top module: `cpu_stat_ctl`

## Requirements
- R1: While `rst_n` is low the register reads 8'h11: only bit 4 (power-on cause) and bit 0 (run) are set, `run` is 1 and `susp_req` is 0.
- R2: A `wdt_rst` strobe sets bit 6 and bit 0 and clears bit 7 and bits 3 to 1. Bits 5 and 4 keep their values. The strobe wins over a halt or a write in the same cycle.
- R3: A `halt_op` strobe without `wdt_rst` clears all eight bits. This wins over every write and hardware event in that cycle, so `run` goes to 0.
- R4: Through a write, a 0 clears bit 6, 5 or 4 and a 1 leaves it unchanged. If hardware sets one of these bits in the same cycle that a write clears it, the bit ends up set.
- R5: A `se0_det` pulse sets bit 5, the bus-reset flag.
- R6: A write with data bit 3 set sets bit 3 (suspend) unless `bus_active` is high in that cycle, in which case the request is dropped. A write with data bit 3 clear clears it. `susp_req` equals bit 3, and `run` is bit 0 AND NOT bit 3.
- R7: Suspend clears when `bus_active` is high, or when an interrupt is pending (`irq_seen` or bit 7) while bit 2 is set. A wake condition wins over a suspend request in the same cycle.
- R8: Bit 2 (interrupt enable) is set by `ei_op` and cleared by `di_op`. `reti_op` loads it from `reti_ie`, with priority reti over ei over di. Writes do not affect it, and a watchdog reset or a halt clears it.
- R9: Bit 7 is set by `irq_seen` and cleared by `irq_ack`. When both occur in one cycle the set wins. Writes do not affect it.
- R10: Bit 1 always reads 0. Bit 0 takes the written data bit 0 on every write.
- R11: `stat_q` is the register itself, with bit positions 7 pending, 6 watchdog cause, 5 bus reset, 4 power-on cause, 3 suspend, 2 interrupt enable, 1 reserved, 0 run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Power-on reset, asynchronous, active low |
| wdt_rst | input | 1 | Watchdog reset strobe |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 8 | Write data |
| halt_op | input | 1 | Halt instruction strobe |
| di_op | input | 1 | Disable-interrupts instruction strobe |
| ei_op | input | 1 | Enable-interrupts instruction strobe |
| reti_op | input | 1 | Return-from-interrupt strobe |
| reti_ie | input | 1 | Enable state restored by return-from-interrupt |
| se0_det | input | 1 | Upstream bus-reset detected pulse |
| bus_active | input | 1 | Bus activity present |
| irq_seen | input | 1 | An interrupt has been recognised |
| irq_ack | input | 1 | Interrupt handling sequence taking the interrupt |
| stat_q | output | 8 | Register value |
| run | output | 1 | Core may execute |
| susp_req | output | 1 | Low-power suspend request |

## Verification
The assertions check on every cycle the image a watchdog reset leaves, including the preserved power-on bit, and that a halt zeroes the word. They also check that hardware sets beat firmware clears, that a suspend write during bus activity is dropped, and that a write never touches the enable bit. The bench scenarios are what show the ordered histories. These include suspend followed by wake through an interrupt only while interrupts are enabled, return-from-interrupt restoring a saved enable, a cleared power-on bit surviving a later watchdog reset, and a run bit written low and back high.

// File: rtl/stat_pkg.sv
package stat_pkg;

   localparam int REG_W     = 8;
   localparam int N_CAUSE   = 3;

   // Bit positions; firmware decodes these, so they are fixed.
   localparam int B_PEND    = 7;
   localparam int B_WDOG    = 6;
   localparam int B_BUSRST  = 5;
   localparam int B_PWRON   = 4;
   localparam int B_SUSP    = 3;
   localparam int B_IEN     = 2;
   localparam int B_RSVD    = 1;
   localparam int B_RUN     = 0;

   // Cause field order inside the cause-bit bank: [2]=watchdog, [1]=bus reset, [0]=power-on.
   localparam logic [N_CAUSE-1:0] CAUSE_WDOG_MASK = 3'b100;
   localparam logic [N_CAUSE-1:0] CAUSE_PWRON_VAL = 3'b001;

   typedef struct packed {
      logic       pend;
      logic [2:0] cause;
      logic       susp;
      logic       ien;
      logic       rsvd;
      logic       run;
   } stat_word_t;

endpackage

// File: rtl/stat_cause_bits.sv
module stat_cause_bits #(
   parameter int                 N        = 3,
   parameter logic [N-1:0]       WDOG_SET = 3'b100,
   parameter logic [N-1:0]       PON_VAL  = 3'b001
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         wdt_rst,
   input  logic         halt_op,
   input  logic         wr_en,
   input  logic [N-1:0] wr_bits,
   input  logic [N-1:0] hw_set,
   output logic [N-1:0] cause_q
);

   if (N < 1) begin : g_bad_n
      $error("stat_cause_bits: N must be at least 1");
   end

   for (genvar i = 0; i < N; i++) begin : g_bit
      if (WDOG_SET[i]) begin : g_wdog
         // Bit forced high by the watchdog strobe.
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                      cause_q[i] <= PON_VAL[i];
            else if (wdt_rst)                cause_q[i] <= 1'b1;
            else if (halt_op)                cause_q[i] <= 1'b0;
            else if (hw_set[i])              cause_q[i] <= 1'b1;
            else if (wr_en && !wr_bits[i])   cause_q[i] <= 1'b0;
         end
      end else begin : g_keep
         // Bit preserved across the watchdog strobe (a set still lands).
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                      cause_q[i] <= PON_VAL[i];
            else if (wdt_rst)                cause_q[i] <= cause_q[i] | hw_set[i];
            else if (halt_op)                cause_q[i] <= 1'b0;
            else if (hw_set[i])              cause_q[i] <= 1'b1;
            else if (wr_en && !wr_bits[i])   cause_q[i] <= 1'b0;
         end
      end

      // R4: a hardware set wins over a same-cycle firmware clear
      p_hw_set_wins_r4: assert property (@(posedge clk) disable iff (!rst_n)
         $past(hw_set[i] && !halt_op) |-> cause_q[i]);
   end

endmodule

// File: rtl/stat_irq_ien.sv
module stat_irq_ien (
   input  logic clk,
   input  logic rst_n,
   input  logic wdt_rst,
   input  logic halt_op,
   input  logic di_op,
   input  logic ei_op,
   input  logic reti_op,
   input  logic reti_ie,
   input  logic irq_seen,
   input  logic irq_ack,
   output logic ien_q,
   output logic pend_q
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        ien_q <= 1'b0;
      else if (wdt_rst)  ien_q <= 1'b0;
      else if (halt_op)  ien_q <= 1'b0;
      else if (reti_op)  ien_q <= reti_ie;
      else if (ei_op)    ien_q <= 1'b1;
      else if (di_op)    ien_q <= 1'b0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        pend_q <= 1'b0;
      else if (wdt_rst)  pend_q <= 1'b0;
      else if (halt_op)  pend_q <= 1'b0;
      else if (irq_seen) pend_q <= 1'b1;
      else if (irq_ack)  pend_q <= 1'b0;
   end

   // R9: recognition wins over acknowledge
   p_pend_set_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $past(irq_seen && !wdt_rst && !halt_op) |-> pend_q);

   // R8: enable instruction takes effect next cycle
   p_ei_sets_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $past(ei_op && !reti_op && !wdt_rst && !halt_op) |-> ien_q);

endmodule

// File: rtl/stat_susp_run.sv
module stat_susp_run (
   input  logic clk,
   input  logic rst_n,
   input  logic wdt_rst,
   input  logic halt_op,
   input  logic wr_en,
   input  logic wr_run,
   input  logic wr_susp,
   input  logic bus_active,
   input  logic wake_irq,
   output logic run_q,
   output logic susp_q
);

   logic wake;
   logic susp_try;

   assign wake     = bus_active | wake_irq;
   assign susp_try = wr_en & wr_susp & ~bus_active;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        run_q <= 1'b1;
      else if (wdt_rst)  run_q <= 1'b1;
      else if (halt_op)  run_q <= 1'b0;
      else if (wr_en)    run_q <= wr_run;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                 susp_q <= 1'b0;
      else if (wdt_rst)           susp_q <= 1'b0;
      else if (halt_op)           susp_q <= 1'b0;
      else if (wake)              susp_q <= 1'b0;
      else if (susp_try)          susp_q <= 1'b1;
      else if (wr_en && !wr_susp) susp_q <= 1'b0;
   end

   // R6: a suspend write during bus activity is dropped
   p_susp_refused_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $past(wr_en && wr_susp && bus_active && !susp_q) |-> !susp_q);

   // R7: bus activity ends suspend
   p_bus_wakes_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $past(susp_q && bus_active) |-> !susp_q);

endmodule

// File: rtl/cpu_stat_ctl.sv
module cpu_stat_ctl #(
   parameter int REG_W = stat_pkg::REG_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wdt_rst,
   input  logic             wr_en,
   input  logic [REG_W-1:0] wr_data,
   input  logic             halt_op,
   input  logic             di_op,
   input  logic             ei_op,
   input  logic             reti_op,
   input  logic             reti_ie,
   input  logic             se0_det,
   input  logic             bus_active,
   input  logic             irq_seen,
   input  logic             irq_ack,
   output logic [REG_W-1:0] stat_q,
   output logic             run,
   output logic             susp_req
);
   import stat_pkg::*;

   if (REG_W != $bits(stat_word_t)) begin : g_bad_width
      $error("cpu_stat_ctl: REG_W must match the status word width");
   end

   logic [N_CAUSE-1:0] cause_q;
   logic [N_CAUSE-1:0] cause_hw;
   logic               ien_q;
   logic               pend_q;
   logic               run_q;
   logic               susp_q;
   logic               wake_irq;
   stat_word_t         word;
   logic               unused_wr;

   assign cause_hw  = {1'b0, se0_det, 1'b0};
   assign wake_irq  = (irq_seen | pend_q) & ien_q;
   assign unused_wr = ^{wr_data[B_PEND], wr_data[B_IEN], wr_data[B_RSVD]};

   stat_cause_bits #(
      .N        (N_CAUSE),
      .WDOG_SET (CAUSE_WDOG_MASK),
      .PON_VAL  (CAUSE_PWRON_VAL)
   ) i_cause (
      .clk     (clk),
      .rst_n   (rst_n),
      .wdt_rst (wdt_rst),
      .halt_op (halt_op),
      .wr_en   (wr_en),
      .wr_bits (wr_data[B_WDOG:B_PWRON]),
      .hw_set  (cause_hw),
      .cause_q (cause_q)
   );

   stat_irq_ien i_irq (
      .clk      (clk),
      .rst_n    (rst_n),
      .wdt_rst  (wdt_rst),
      .halt_op  (halt_op),
      .di_op    (di_op),
      .ei_op    (ei_op),
      .reti_op  (reti_op),
      .reti_ie  (reti_ie),
      .irq_seen (irq_seen),
      .irq_ack  (irq_ack),
      .ien_q    (ien_q),
      .pend_q   (pend_q)
   );

   stat_susp_run i_run (
      .clk        (clk),
      .rst_n      (rst_n),
      .wdt_rst    (wdt_rst),
      .halt_op    (halt_op),
      .wr_en      (wr_en),
      .wr_run     (wr_data[B_RUN]),
      .wr_susp    (wr_data[B_SUSP]),
      .bus_active (bus_active),
      .wake_irq   (wake_irq),
      .run_q      (run_q),
      .susp_q     (susp_q)
   );

   always_comb begin
      word.pend  = pend_q;
      word.cause = cause_q;
      word.susp  = susp_q;
      word.ien   = ien_q;
      word.rsvd  = 1'b0;
      word.run   = run_q;
   end

   assign stat_q   = word;
   assign run      = run_q & ~susp_q;
   assign susp_req = susp_q;

   // R3: halt leaves an all-zero word
   p_halt_clears_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $past(halt_op && !wdt_rst) |-> (stat_q == '0));

   // R2: watchdog image
   p_wdog_image_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $past(wdt_rst) |-> (!stat_q[B_PEND] && stat_q[B_WDOG] &&
                          stat_q[B_SUSP:B_RSVD] == 3'b000 && stat_q[B_RUN]));

   // R2: power-on cause survives a watchdog reset
   p_wdog_keeps_pwron_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $past(wdt_rst) |-> (stat_q[B_PWRON] == $past(stat_q[B_PWRON])));

   // R8: a write alone never moves the enable bit
   p_ien_write_ignored_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !ei_op && !di_op && !reti_op && !wdt_rst && !halt_op)
      |=> $stable(stat_q[B_IEN]));

endmodule

// File: tb/test_cpu_stat_ctl.sv
module test_cpu_stat_ctl;

   localparam int NV = 26;
   // {wr_en, wr_data, halt,di,ei,reti,rie,wdt,se0,bact,iseen,iack, expected}
   localparam logic [26:0] VEC [NV] = '{
      {1'b0, 8'h00, 10'b0000000000, 8'h11},  // R1 idle after reset
      {1'b0, 8'h00, 10'b0010000000, 8'h15},  // R8 ei
      {1'b1, 8'hFF, 10'b0000000000, 8'h1D},  // R4 R6 R9 R10 write all ones
      {1'b0, 8'h00, 10'b0000000100, 8'h15},  // R7 bus activity wakes
      {1'b1, 8'h19, 10'b0000000100, 8'h15},  // R6 suspend refused
      {1'b1, 8'h19, 10'b0000000000, 8'h1D},  // R6 suspend accepted
      {1'b0, 8'h00, 10'b0000000010, 8'h95},  // R7 R9 irq wakes while enabled
      {1'b0, 8'h00, 10'b0000000001, 8'h15},  // R9 ack
      {1'b0, 8'h00, 10'b0000001000, 8'h35},  // R5 bus reset
      {1'b1, 8'h05, 10'b0000001000, 8'h25},  // R4 set beats clear, por cleared
      {1'b0, 8'h00, 10'b0100000000, 8'h21},  // R8 di
      {1'b0, 8'h00, 10'b0001100000, 8'h25},  // R8 reti restores 1
      {1'b0, 8'h00, 10'b0000010000, 8'h61},  // R2 watchdog keeps 5 and 4
      {1'b1, 8'h01, 10'b0000000000, 8'h01},  // R4 clear causes
      {1'b0, 8'h00, 10'b0000000010, 8'h81},  // R9 pending, enable off
      {1'b0, 8'h00, 10'b0000010000, 8'h41},  // R2 watchdog clears pending
      {1'b0, 8'h00, 10'b1000000000, 8'h00},  // R3 halt
      {1'b0, 8'h00, 10'b0000001000, 8'h20},  // R5 bus reset while halted
      {1'b0, 8'h00, 10'b0000010000, 8'h61},  // R2 watchdog after halt
      {1'b0, 8'h00, 10'b1000001000, 8'h00},  // R3 halt beats bus reset
      {1'b1, 8'h01, 10'b0000010000, 8'h41},  // R2 watchdog beats write
      {1'b1, 8'h40, 10'b0000000000, 8'h40},  // R10 run written low
      {1'b1, 8'h41, 10'b0000000000, 8'h41},  // R10 run written high
      {1'b0, 8'h00, 10'b0010000000, 8'h45},  // R8 ei
      {1'b1, 8'h4D, 10'b0000000010, 8'hC5},  // R7 wake beats suspend set
      {1'b0, 8'h00, 10'b0000000001, 8'h45}   // R9 ack
   };

   string tag [NV] = '{"R1","R8","R4","R7","R6","R6","R7","R9","R5","R4",
                       "R8","R8","R2","R4","R9","R2","R3","R5","R2","R3",
                       "R2","R10","R10","R8","R7","R9"};

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       wdt_rst = 1'b0, wr_en = 1'b0, halt_op = 1'b0, di_op = 1'b0;
   logic       ei_op = 1'b0, reti_op = 1'b0, reti_ie = 1'b0, se0_det = 1'b0;
   logic       bus_active = 1'b0, irq_seen = 1'b0, irq_ack = 1'b0;
   logic [7:0] wr_data = 8'h00;
   logic [7:0] stat_q;
   logic       run, susp_req;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   cpu_stat_ctl i_cpu_stat_ctl (
      .clk(clk), .rst_n(rst_n), .wdt_rst(wdt_rst), .wr_en(wr_en),
      .wr_data(wr_data), .halt_op(halt_op), .di_op(di_op), .ei_op(ei_op),
      .reti_op(reti_op), .reti_ie(reti_ie), .se0_det(se0_det),
      .bus_active(bus_active), .irq_seen(irq_seen), .irq_ack(irq_ack),
      .stat_q(stat_q), .run(run), .susp_req(susp_req)
   );

   task automatic check(input string req, input string what,
                        input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   // R6: susp_req is bit 3; run is bit 0 and not bit 3
   task automatic check_word(input string req, input logic [7:0] exp);
      check(req, "stat_q", stat_q, exp);
      check(req, "run", {7'd0, run}, {7'd0, exp[0] & ~exp[3]});
      check(req, "susp_req", {7'd0, susp_req}, {7'd0, exp[3]});
   endtask

   initial begin
      #(200000 * 5);
      if (!done) begin
         failures++;
         $display("FAIL watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      check_word("R1", 8'h11);            // R1 during reset
      rst_n = 1'b1;
      for (int i = 0; i < NV; i++) begin
         {wr_en, wr_data, halt_op, di_op, ei_op, reti_op, reti_ie,
          wdt_rst, se0_det, bus_active, irq_seen, irq_ack} = VEC[i][26:8];
         @(negedge clk);
         check_word(tag[i], VEC[i][7:0]);
      end
      {wr_en, wr_data, halt_op, di_op, ei_op, reti_op, reti_ie,
       wdt_rst, se0_det, bus_active, irq_seen, irq_ack} = '0;
      // R11: idle cycle holds the value
      @(negedge clk);
      check_word("R11", 8'h45);
      // R1: power-on reset mid-run restores the start value
      rst_n = 1'b0;
      #1;
      check_word("R1", 8'h11);
      @(negedge clk);
      rst_n = 1'b1;
      // R5: bus reset then R4 write-one leaves it set
      se0_det = 1'b1;
      @(negedge clk);
      se0_det = 1'b0;
      wr_en = 1'b1; wr_data = 8'h31;
      @(negedge clk);
      wr_en = 1'b0;
      check_word("R4", 8'h31);
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule